// File: doc/BRIEF.md
# DMA Bus Transfer Cycle Sequencer

This block runs the bus cycles for one DMA channel after that channel has been given the bus. A transfer starts when `go` is sampled high while the block is idle. At that point the block latches the transfer kind, the source address and the destination address. It then steps through a fixed order of states. The first state puts the upper address byte on the shared data bus and pulses an address-latch strobe. The second and third states assert the active-low strobes. The third state repeats while READY is low. The fourth state releases the strobes. After the fourth state the block returns to idle or starts the next phase.

There are two peripheral kinds. In each one a memory strobe and an I/O strobe are asserted together, so data passes straight between memory and the device. In the memory-to-memory kind the block runs two back-to-back cycles. The first is a memory read whose data is captured into an internal holding register. The second is a memory write that drives that held byte out on the data bus to the destination address. The I/O strobes are bidirectional outside this block. They are only driven while a transfer is in progress, as shown by `io_oe`. A one-clock `done` pulse lets an external counter advance once per completed transfer.

Top module: `dma_cycle_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the block is idle. In idle all four strobes are high, and `adstb`, `data_oe`, `io_oe`, `busy` and `done` are low. `data_out` and `addr_lo` are zero.
- R2: In the first state of every cycle, `adstb` is high and `data_oe` is high. In that state `data_out` carries bits [15:8] of the cycle's address, and `addr_lo` carries bits [7:0] of that address. `addr_lo` holds its value from the first state through the fourth. `adstb` is low in every other state.
- R3: Kind 2'b00 moves data from the device to memory. It drives `ior_n` and `memw_n` low in the second state and in every third-state cycle, and keeps `memr_n` and `iow_n` high.
- R4: Kind 2'b01 moves data from memory to the device. It drives `memr_n` and `iow_n` low in the second state and in every third-state cycle, and keeps `ior_n` and `memw_n` high.
- R5: Each clock on which READY is sampled low in the third state adds one more third-state cycle with the strobes still asserted. The fourth state, with all strobes high, follows the first third-state cycle in which READY is sampled high.
- R6: `io_oe` and `busy` are high from the first state through the fourth state of any transfer, and low in idle.
- R7: Kind 2'b10 is memory to memory. Its read phase uses the source address and drives `memr_n` low. The byte on `data_in` in the last third-state cycle is captured. The write phase that follows uses the destination address and drives `memw_n` low. From the second state through the fourth state of the write phase it drives the captured byte on `data_out` with `data_oe` high. The I/O strobes stay high throughout this kind.
- R8: `done` is high for exactly the one clock of the fourth state of a peripheral transfer, and of the write phase of a memory-to-memory transfer. It is low in the fourth state of the read phase.
- R9: `data_oe` is low in states two to four of peripheral transfers and of the memory-to-memory read phase.
- R10: `go`, `kind` and the address inputs are ignored while a transfer is in progress. The running transfer keeps the kind and addresses latched at its start, and the block returns to idle after its fourth state.
- R11: `go` with kind 2'b11 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, sampled only in idle |
| kind | input | 2 | Transfer kind: 00 device to memory, 01 memory to device, 10 memory to memory, 11 ignored |
| src_addr | input | 16 | Address for peripheral transfers and for the memory-to-memory read phase |
| dst_addr | input | 16 | Address for the memory-to-memory write phase |
| ready | input | 1 | Stretches the strobes while low in the third state |
| data_in | input | 8 | Data bus input, captured in the memory-to-memory read phase |
| data_out | output | 8 | Data bus output: upper address byte, or held byte |
| data_oe | output | 1 | Data bus output enable |
| addr_lo | output | 8 | Low address byte |
| adstb | output | 1 | Address-latch strobe for the upper byte |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| io_oe | output | 1 | Output enable for the I/O strobes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse at the end of a transfer |

## Verification
In a memory-to-memory transfer, READY rising and the capture of the held byte fall on the same clock edge. The byte taken is whatever sits on `data_in` at the edge where READY is first seen high. To provoke this, the bench stretches the read phase with several low READY cycles and puts a different noise byte on `data_in` in each one. It presents the real byte only in the cycle where READY rises. The bench then judges the result by checking that the write phase drives exactly that real byte, and none of the noise values, on `data_out`.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    K_DEV2MEM = 2'b00,
    K_MEM2DEV = 2'b01,
    K_MEM2MEM = 2'b10,
    K_RSVD    = 2'b11
  } xfer_kind_e;

endpackage

// File: rtl/dmaseq_fsm.sv
module dmaseq_fsm
  import dmaseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          ready,
  output seq_st_e       st_d,
  output logic          wph_d,
  output xfer_kind_e    kind_d,
  output logic [AW-1:0] src_d,
  output logic [AW-1:0] dst_d,
  output logic          capture
);

  seq_st_e       st_q;
  logic          wph_q;
  xfer_kind_e    kind_q;
  logic [AW-1:0] src_q;
  logic [AW-1:0] dst_q;

  always_comb begin
    st_d   = st_q;
    wph_d  = wph_q;
    kind_d = kind_q;
    src_d  = src_q;
    dst_d  = dst_q;
    unique case (st_q)
      ST_IDLE: begin
        if (go && (xfer_kind_e'(kind) != K_RSVD)) begin
          st_d   = ST_S1;
          wph_d  = 1'b0;
          kind_d = xfer_kind_e'(kind);
          src_d  = src_addr;
          dst_d  = dst_addr;
        end
      end
      ST_S1: st_d = ST_S2;
      ST_S2: st_d = ST_S3;
      ST_S3: if (ready) st_d = ST_S4;
      ST_S4: begin
        if ((kind_q == K_MEM2MEM) && !wph_q) begin
          st_d  = ST_S1;
          wph_d = 1'b1;
        end else begin
          st_d  = ST_IDLE;
          wph_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign capture = (st_q == ST_S3) && ready && (kind_q == K_MEM2MEM) && !wph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wph_q  <= 1'b0;
      kind_q <= K_DEV2MEM;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      st_q   <= st_d;
      wph_q  <= wph_d;
      kind_q <= kind_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
    end
  end

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_S3 && !ready) |=> (st_q == ST_S3)); // R5

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && st_q != ST_S4) |=> $stable(kind_q)); // R10

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && go && kind == 2'b11) |=> (st_q == ST_IDLE)); // R11

endmodule

// File: rtl/dmaseq_hold.sv
module dmaseq_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] tmp_d
);

  logic [DW-1:0] tmp_q;

  assign tmp_d = capture ? data_in : tmp_q;

  always_ff @(posedge clk) begin
    if (rst) tmp_q <= '0;
    else     tmp_q <= tmp_d;
  end

  AST_CAPTURE_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
    capture |=> (tmp_q == $past(data_in))); // R7

endmodule

// File: rtl/dmaseq_drv.sv
module dmaseq_drv
  import dmaseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_st_e       st_d,
  input  logic          wph_d,
  input  xfer_kind_e    kind_d,
  input  logic [AW-1:0] src_d,
  input  logic [AW-1:0] dst_d,
  input  logic [DW-1:0] tmp_d,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] addr_lo,
  output logic          adstb,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n,
  output logic          io_oe,
  output logic          busy,
  output logic          done
);

  logic          act, strb, m2m_wr, m2m_rd;
  logic [AW-1:0] cyc_addr;

  always_comb begin
    act      = (st_d != ST_IDLE);
    strb     = (st_d == ST_S2) || (st_d == ST_S3);
    m2m_wr   = act && (kind_d == K_MEM2MEM) && wph_d;
    m2m_rd   = act && (kind_d == K_MEM2MEM) && !wph_d;
    cyc_addr = m2m_wr ? dst_d : src_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
      addr_lo  <= '0;
      adstb    <= 1'b0;
      memr_n   <= 1'b1;
      memw_n   <= 1'b1;
      ior_n    <= 1'b1;
      iow_n    <= 1'b1;
      io_oe    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      adstb    <= (st_d == ST_S1);
      data_oe  <= (st_d == ST_S1) || m2m_wr;
      data_out <= (st_d == ST_S1) ? cyc_addr[AW-1:DW] : (m2m_wr ? tmp_d : '0);
      addr_lo  <= act ? cyc_addr[DW-1:0] : '0;
      memr_n   <= !(strb && ((kind_d == K_MEM2DEV) || m2m_rd));
      memw_n   <= !(strb && ((kind_d == K_DEV2MEM) || m2m_wr));
      ior_n    <= !(strb && (kind_d == K_DEV2MEM));
      iow_n    <= !(strb && (kind_d == K_MEM2DEV));
      io_oe    <= act;
      busy     <= act;
      done     <= (st_d == ST_S4) && !m2m_rd;
    end
  end

  AST_ADSTB_STROBES_IDLE: assert property (@(posedge clk) disable iff (rst)
    adstb |-> (data_oe && memr_n && memw_n && ior_n && iow_n)); // R2

  AST_NO_MEM_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    !(!memr_n && !memw_n)); // R7

  AST_IO_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (!ior_n || !iow_n) |-> io_oe); // R6

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done && !adstb) |-> (memr_n && memw_n && ior_n && iow_n)); // R8

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dmaseq_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          ready,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] addr_lo,
  output logic          adstb,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n,
  output logic          io_oe,
  output logic          busy,
  output logic          done
);

  seq_st_e       st_d;
  logic          wph_d;
  xfer_kind_e    kind_d;
  logic [AW-1:0] src_d;
  logic [AW-1:0] dst_d;
  logic          capture;
  logic [DW-1:0] tmp_d;

  dmaseq_fsm #(.DW(DW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .kind     (kind),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .ready    (ready),
    .st_d     (st_d),
    .wph_d    (wph_d),
    .kind_d   (kind_d),
    .src_d    (src_d),
    .dst_d    (dst_d),
    .capture  (capture)
  );

  dmaseq_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .data_in (data_in),
    .tmp_d   (tmp_d)
  );

  dmaseq_drv #(.DW(DW)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .st_d     (st_d),
    .wph_d    (wph_d),
    .kind_d   (kind_d),
    .src_d    (src_d),
    .dst_d    (dst_d),
    .tmp_d    (tmp_d),
    .data_out (data_out),
    .data_oe  (data_oe),
    .addr_lo  (addr_lo),
    .adstb    (adstb),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .io_oe    (io_oe),
    .busy     (busy),
    .done     (done)
  );

  AST_OE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> io_oe); // R6

endmodule

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb;

  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  din;
    logic [3:0]  waits;
    logic [7:0]  exp_wdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 16'h12A5, 16'h0000, 8'h00, 4'd0, 8'h00},
    '{2'b01, 16'hBEEF, 16'h0000, 8'h00, 4'd0, 8'h00},
    '{2'b00, 16'h3C01, 16'h0000, 8'h00, 4'd3, 8'h00},
    '{2'b01, 16'hFF80, 16'h0000, 8'h00, 4'd2, 8'h00},
    '{2'b10, 16'h4411, 16'h9922, 8'h5A, 4'd0, 8'h5A},
    '{2'b10, 16'h0107, 16'hE0F3, 8'hC3, 4'd4, 8'hC3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [1:0]  kind = 2'b00;
  logic [15:0] src_addr = '0;
  logic [15:0] dst_addr = '0;
  logic        ready = 1'b0;
  logic [7:0]  data_in = '0;
  logic [7:0]  data_out, addr_lo;
  logic        data_oe, adstb, memr_n, memw_n, ior_n, iow_n, io_oe, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_cycle_seq u_dut (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .src_addr(src_addr),
    .dst_addr(dst_addr), .ready(ready), .data_in(data_in), .data_out(data_out),
    .data_oe(data_oe), .addr_lo(addr_lo), .adstb(adstb), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .io_oe(io_oe),
    .busy(busy), .done(done)
  );

  function automatic logic [24:0] obs();
    return {adstb, data_oe, data_out, addr_lo, memr_n, memw_n, ior_n, iow_n, io_oe, busy, done};
  endfunction

  // stage: 0 idle, 1..4 = first..fourth state
  function automatic logic [24:0] expv(logic [1:0] k, bit wph, int stage,
                                       logic [15:0] s, logic [15:0] d, logic [7:0] t);
    logic [15:0] a;
    bit on, wr, rd;
    if (stage == 0) return {2'b00, 8'h00, 8'h00, 4'b1111, 3'b000};
    wr = (k == 2'b10) && wph;
    rd = (k == 2'b10) && !wph;
    a  = wr ? d : s;
    on = (stage == 2) || (stage == 3);
    return {stage == 1, (stage == 1) || wr,
            (stage == 1) ? a[15:8] : (wr ? t : 8'h00), a[7:0],
            !(on && (k == 2'b01 || rd)), !(on && (k == 2'b00 || wr)),
            !(on && k == 2'b00), !(on && k == 2'b01),
            1'b1, 1'b1, (stage == 4) && !rd};
  endfunction

  task automatic check(string tag, logic [24:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, obs(), exp, cycles);
    end
  endtask

  task automatic run_xfer(vec_t v, bit poke);
    int nph;
    string t_strb;
    @(negedge clk);
    go = 1'b1; kind = v.kind; src_addr = v.src; dst_addr = v.dst; ready = 1'b0;
    @(negedge clk);
    go = 1'b0;
    nph = (v.kind == 2'b10) ? 2 : 1;
    t_strb = (v.kind == 2'b00) ? "R3" : (v.kind == 2'b01) ? "R4" : "R7";
    for (int ph = 0; ph < nph; ph++) begin
      check(poke ? "R10" : "R2", expv(v.kind, ph == 1, 1, v.src, v.dst, v.exp_wdata));
      @(negedge clk);
      if (poke) begin go = 1'b1; kind = 2'b10; src_addr = ~v.src; dst_addr = 16'h5555; end
      check(poke ? "R10" : t_strb, expv(v.kind, ph == 1, 2, v.src, v.dst, v.exp_wdata));
      @(negedge clk);
      go = 1'b0;
      for (int j = 0; j <= int'(v.waits); j++) begin
        ready = (j == int'(v.waits));
        data_in = (j == int'(v.waits)) ? v.din : (~v.din ^ 8'(j * 37 + 1));
        check((v.waits != 0) ? "R5" : t_strb,
              expv(v.kind, ph == 1, 3, v.src, v.dst, v.exp_wdata));
        @(negedge clk);
      end
      ready = 1'b0;
      data_in = 8'hEE;
      check(v.kind == 2'b10 ? "R7" : "R8", expv(v.kind, ph == 1, 4, v.src, v.dst, v.exp_wdata));
      @(negedge clk);
    end
    check(poke ? "R10" : "R9", expv(v.kind, 1'b0, 0, v.src, v.dst, v.exp_wdata));
  endtask

  initial begin
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", expv(2'b00, 1'b0, 0, '0, '0, '0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", expv(2'b00, 1'b0, 0, '0, '0, '0));

    for (int i = 0; i < NV; i++) run_xfer(VEC[i], 1'b0);

    // R10: inputs changed mid-transfer are ignored
    run_xfer(VEC[1], 1'b1);

    // R11: reserved kind is ignored
    @(negedge clk);
    go = 1'b1; kind = 2'b11; src_addr = 16'hA5A5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11", expv(2'b00, 1'b0, 0, '0, '0, '0));
    end
    go = 1'b0;

    // R1: reset in the middle of a transfer returns to idle
    @(negedge clk);
    go = 1'b1; kind = 2'b01; src_addr = 16'h7777;
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    check("R4", expv(2'b01, 1'b0, 2, 16'h7777, '0, '0));
    rst = 1'b1;
    @(negedge clk);
    check("R1", expv(2'b00, 1'b0, 0, '0, '0, '0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", expv(2'b00, 1'b0, 0, '0, '0, '0));

    // R6/R9: one more transfer after reset behaves normally
    run_xfer(VEC[4], 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule